// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing half of a byte-addressed serial memory. It watches a two-wire bus (clock and data) through synchronisers clocked by the system clock, finds start and stop conditions, shifts bytes in and out MSB first, and pulls the data line low for acknowledges and for zero bits it transmits. The data line is open drain: the block only ever asks for a pull-down.

A transfer opens with a select byte whose upper nibble is the fixed type code and whose next two bits must match two strap pins. The select byte also carries the top bit of a 17-bit byte address and the direction bit. A write-direction select byte is followed by the high and low address bytes and then by data bytes. Each data byte is handed to a companion block on a simple synchronous write strobe. A read-direction select byte starts streaming from the internal address pointer. The pointer advances after every byte, so the block supports random reads (an address-setting write, a repeated start, then a read), current-address reads and sequential reads.

The memory side is a plain synchronous port. A read strobe presents an address, and the byte is expected on the read-data input in the next cycle. A write strobe presents an address and a byte for one cycle.

Top module: `tws_mem_slave`

## Requirements
- R1: While reset is high and in the first cycle after it, the data pull-down output is 0 and neither memory strobe is asserted.
- R2: A select byte is acknowledged only when its bits 7..4 are 1010 and its bits 3..2 equal chip_en_i[1:0] (bit 3 is compared with chip_en_i[1]). The acknowledge is a pull-down held through the ninth clock of the byte.
- R3: A select byte that does not match gets no acknowledge. The block then drives nothing and issues no memory strobe until the next start.
- R4: After a write-direction select byte (bit 0 = 0), the next two bytes are acknowledged and form the address {select bit 1, first byte, second byte}. The first byte is the high byte.
- R5: Every data byte that follows the two address bytes is acknowledged and produces exactly one write strobe carrying the current address and that byte. The address then advances by one. A read strobe and a write strobe are never active together.
- R6: A read-direction select byte (bit 0 = 1) issues a read strobe at the current address. The returned byte is sent MSB first, and the pull-down output changes only while the synchronised clock is low, or right after a start or stop.
- R7: When the master acknowledges a read byte (data low in the ninth clock), the next byte comes from the following address. When the master does not acknowledge, the block releases the data line and sends nothing more.
- R8: A random read sends the address in write direction, then a repeated start and a read-direction select byte. It returns the byte at that address.
- R9: The address pointer wraps from 0x1FFFF to 0x00000. A current-address read starts at one past the last byte read or written.
- R10: A start at any point aborts the byte in progress and restarts select-byte reception.
- R11: A stop returns the block to idle. Clock pulses that follow without a new start get no acknowledge and cause no memory strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line level, asynchronous |
| chip_en_i | input | 2 | Strap pins matched against select bits 3..2 |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| mem_addr_o | output | 17 | Memory byte address |
| mem_rd_o | output | 1 | One-cycle read strobe |
| mem_wr_o | output | 1 | One-cycle write strobe |
| mem_wdata_o | output | 8 | Byte to write |
| mem_rdata_i | input | 8 | Byte read, valid the cycle after mem_rd_o |

## Verification
A bus edge reaches the controller three system cycles after the pin changes: two synchroniser flops and one comparison register. Acknowledge and data bits therefore move on the data line about three cycles after the clock falls. The bench holds each clock phase for eight cycles, changes data four cycles into the low phase, and samples the line in the middle of the high phase, so every bus-level result is settled when it is read. Memory strobes come one cycle after the triggering edge is detected, and read data is registered one cycle after the strobe. The bench therefore checks strobe logs only after a stop or after a whole byte, never at the edge itself.

// File: rtl/tws_pkg.sv
`timescale 1ns/1ps
package tws_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2 * BYTE_W + 1;
    localparam int CNT_W  = 4;
    localparam logic [3:0] TYPE_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WR,
        ST_RD
    } bus_st_e;

    typedef struct packed {
        logic scl_lvl;
        logic sda_lvl;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    typedef struct packed {
        logic [3:0] type_code;
        logic [1:0] chip;
        logic       a_top;
        logic       rd;
    } sel_byte_t;

    function automatic logic sel_match(input sel_byte_t s, input logic [1:0] chip);
        return (s.type_code == TYPE_CODE) && (s.chip == chip);
    endfunction
endpackage

// File: rtl/tws_line_sync.sv
`timescale 1ns/1ps
module tws_line_sync
    import tws_pkg::*;
#(
    parameter int STAGES = 2
)(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);
    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_p;
    logic              sda_p;
    logic              scl_s;
    logic              sda_s;

    generate
        if (STAGES > 1) begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= {scl_sh[STAGES-2:0], scl_i};
                    sda_sh <= {sda_sh[STAGES-2:0], sda_i};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= scl_i;
                    sda_sh <= sda_i;
                end
            end
        end
    endgenerate

    assign scl_s = scl_sh[STAGES-1];
    assign sda_s = sda_sh[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    always_comb begin
        ev.scl_lvl  = scl_s;
        ev.sda_lvl  = sda_s;
        ev.scl_rise = scl_s & ~scl_p;
        ev.scl_fall = ~scl_s & scl_p;
        ev.start    = scl_s & scl_p & sda_p & ~sda_s;
        ev.stop     = scl_s & scl_p & ~sda_p & sda_s;
    end
endmodule

// File: rtl/tws_addr_ptr.sv
`timescale 1ns/1ps
module tws_addr_ptr #(
    parameter int W = 17
)(
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         inc,
    output logic [W-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (ld) begin
            ptr <= ld_val;
        end else if (inc) begin
            ptr <= ptr + W'(1);
        end
    end
endmodule

// File: rtl/tws_ctrl.sv
`timescale 1ns/1ps
module tws_ctrl
    import tws_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  line_ev_t          ev,
    input  logic [1:0]        chip_en_i,
    input  logic [BYTE_W-1:0] mem_rdata_i,
    output bus_st_e           st_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              sda_pull_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [BYTE_W-1:0] mem_wdata_o,
    output logic              ptr_ld_o,
    output logic [ADDR_W-1:0] ptr_ld_val_o,
    output logic              ptr_inc_o
);
    localparam logic [CNT_W-1:0] CNT_ACK = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(BYTE_W + 1);

    bus_st_e           st;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] tx;
    logic [BYTE_W-1:0] hi_q;
    logic              a_top_q;
    logic              rw_q;
    logic              ack_drv;
    logic              m_ack;
    logic              rd_pend;
    sel_byte_t         sel;
    logic [2:0]        bit_idx;

    assign sel     = sel_byte_t'(shreg);
    assign bit_idx = 3'(BYTE_W - 1) - cnt[2:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= ST_IDLE;
            cnt          <= '0;
            shreg        <= '0;
            tx           <= '0;
            hi_q         <= '0;
            a_top_q      <= 1'b0;
            rw_q         <= 1'b0;
            ack_drv      <= 1'b0;
            m_ack        <= 1'b0;
            rd_pend      <= 1'b0;
            mem_rd_o     <= 1'b0;
            mem_wr_o     <= 1'b0;
            mem_wdata_o  <= '0;
            ptr_ld_o     <= 1'b0;
            ptr_ld_val_o <= '0;
            ptr_inc_o    <= 1'b0;
        end else begin
            mem_rd_o  <= 1'b0;
            mem_wr_o  <= 1'b0;
            ptr_ld_o  <= 1'b0;
            ptr_inc_o <= 1'b0;
            rd_pend   <= mem_rd_o;
            if (rd_pend) begin
                tx <= mem_rdata_i;
            end

            if (ev.start) begin
                st      <= ST_DEV;
                cnt     <= '0;
                ack_drv <= 1'b0;
            end else if (ev.stop) begin
                st      <= ST_IDLE;
                cnt     <= '0;
                ack_drv <= 1'b0;
            end else if (st == ST_RD) begin
                if (ev.scl_fall && cnt < CNT_ACK) begin
                    cnt <= cnt + CNT_W'(1);
                end else if (ev.scl_rise && cnt == CNT_ACK) begin
                    m_ack <= ~ev.sda_lvl;
                    if (!ev.sda_lvl) begin
                        mem_rd_o  <= 1'b1;
                        ptr_inc_o <= 1'b1;
                    end
                end else if (ev.scl_fall && cnt == CNT_ACK) begin
                    cnt <= '0;
                    if (!m_ack) begin
                        st <= ST_IDLE;
                    end
                end
            end else if (st != ST_IDLE) begin
                if (ev.scl_rise && cnt < CNT_ACK) begin
                    shreg <= {shreg[BYTE_W-2:0], ev.sda_lvl};
                    cnt   <= cnt + CNT_W'(1);
                end else if (ev.scl_fall && cnt == CNT_ACK) begin
                    cnt     <= CNT_END;
                    ack_drv <= 1'b1;
                    case (st)
                        ST_DEV: begin
                            if (sel_match(sel, chip_en_i)) begin
                                rw_q    <= sel.rd;
                                a_top_q <= sel.a_top;
                                if (sel.rd) begin
                                    mem_rd_o  <= 1'b1;
                                    ptr_inc_o <= 1'b1;
                                end
                            end else begin
                                ack_drv <= 1'b0;
                                st      <= ST_IDLE;
                                cnt     <= '0;
                            end
                        end
                        ST_AHI: hi_q <= shreg;
                        ST_ALO: begin
                            ptr_ld_o     <= 1'b1;
                            ptr_ld_val_o <= {a_top_q, hi_q, shreg};
                        end
                        ST_WR: begin
                            mem_wr_o    <= 1'b1;
                            mem_wdata_o <= shreg;
                            ptr_inc_o   <= 1'b1;
                        end
                        default: ack_drv <= 1'b0;
                    endcase
                end else if (ev.scl_fall && cnt == CNT_END) begin
                    ack_drv <= 1'b0;
                    cnt     <= '0;
                    case (st)
                        ST_DEV:  st <= rw_q ? ST_RD : ST_AHI;
                        ST_AHI:  st <= ST_ALO;
                        ST_ALO:  st <= ST_WR;
                        default: st <= st;
                    endcase
                end
            end
        end
    end

    assign sda_pull_o = ack_drv | ((st == ST_RD) && (cnt < CNT_ACK) && !tx[bit_idx]);
    assign st_o       = st;
    assign cnt_o      = cnt;
endmodule

// File: rtl/tws_mem_slave.sv
`timescale 1ns/1ps
module tws_mem_slave
    import tws_pkg::*;
#(
    parameter int SYNC_STAGES = 2
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        chip_en_i,
    output logic              sda_pull_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [BYTE_W-1:0] mem_wdata_o,
    input  logic [BYTE_W-1:0] mem_rdata_i
);
    line_ev_t          ev;
    bus_st_e           st;
    logic [CNT_W-1:0]  cnt;
    logic              ptr_ld;
    logic              ptr_inc;
    logic [ADDR_W-1:0] ptr_ld_val;

    tws_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    tws_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .ev           (ev),
        .chip_en_i    (chip_en_i),
        .mem_rdata_i  (mem_rdata_i),
        .st_o         (st),
        .cnt_o        (cnt),
        .sda_pull_o   (sda_pull_o),
        .mem_rd_o     (mem_rd_o),
        .mem_wr_o     (mem_wr_o),
        .mem_wdata_o  (mem_wdata_o),
        .ptr_ld_o     (ptr_ld),
        .ptr_ld_val_o (ptr_ld_val),
        .ptr_inc_o    (ptr_inc)
    );

    tws_addr_ptr #(.W(ADDR_W)) u_ptr (
        .clk    (clk),
        .rst    (rst),
        .ld     (ptr_ld),
        .ld_val (ptr_ld_val),
        .inc    (ptr_inc),
        .ptr    (mem_addr_o)
    );
endmodule

// File: rtl/tws_mem_slave_chk.sv
`timescale 1ns/1ps
module tws_mem_slave_chk
    import tws_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             sda_pull_o,
    input logic             mem_rd_o,
    input logic             mem_wr_o,
    input logic             scl_lvl,
    input logic             start_det,
    input logic             stop_det,
    input bus_st_e          st,
    input logic [CNT_W-1:0] cnt
);
    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!sda_pull_o && !mem_rd_o && !mem_wr_o)); // R1

    AST_IDLE_NO_PULL: assert property (@(posedge clk) disable iff (rst) (st == ST_IDLE) |-> !sda_pull_o); // R3

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst) $onehot0({mem_rd_o, mem_wr_o})); // R5

    AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull_o) |-> (!scl_lvl || $past(start_det) || $past(stop_det))); // R6

    AST_RD_ONLY_READING: assert property (@(posedge clk) disable iff (rst)
        mem_rd_o |-> (st == ST_DEV || st == ST_RD)); // R6

    AST_START_RESTART: assert property (@(posedge clk) disable iff (rst)
        start_det |=> (st == ST_DEV && cnt == '0)); // R10

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
        (stop_det && !start_det) |=> (st == ST_IDLE)); // R11
endmodule

bind tws_mem_slave tws_mem_slave_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sda_pull_o (sda_pull_o),
    .mem_rd_o   (mem_rd_o),
    .mem_wr_o   (mem_wr_o),
    .scl_lvl    (ev.scl_lvl),
    .start_det  (ev.start),
    .stop_det   (ev.stop),
    .st         (st),
    .cnt        (cnt)
);

// File: tb/tws_mem_slave_tb.sv
`timescale 1ns/1ps
module tws_mem_slave_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic [1:0]  chip_en = 2'b00;
    logic        sda_pull;
    logic        bus_sda;
    logic [16:0] mem_addr;
    logic        mem_rd;
    logic        mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;

    int n_chk = 0;
    int n_err = 0;
    int wr_n  = 0;
    int rd_n  = 0;
    bit done  = 1'b0;
    logic [16:0] wa [0:7];
    logic [7:0]  wd [0:7];

    always #2.5 clk = ~clk;

    assign bus_sda = m_sda & ~sda_pull;

    tws_mem_slave u_dut (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (m_scl),
        .sda_i       (bus_sda),
        .chip_en_i   (chip_en),
        .sda_pull_o  (sda_pull),
        .mem_addr_o  (mem_addr),
        .mem_rd_o    (mem_rd),
        .mem_wr_o    (mem_wr),
        .mem_wdata_o (mem_wdata),
        .mem_rdata_i (mem_rdata)
    );

    function automatic logic [7:0] pat(input logic [16:0] a);
        return a[7:0] ^ a[15:8] ^ {7'd0, a[16]} ^ 8'h5A;
    endfunction

    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata <= pat(mem_addr);
            rd_n      <= rd_n + 1;
        end
        if (mem_wr) begin
            wa[wr_n[2:0]] <= mem_addr;
            wd[wr_n[2:0]] <= mem_wdata;
            wr_n          <= wr_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_start();
        m_sda = 1'b1; tick(4);
        m_scl = 1'b1; tick(8);
        m_sda = 1'b0; tick(8);
        m_scl = 1'b0; tick(4);
    endtask

    task automatic do_stop();
        m_scl = 1'b0; m_sda = 1'b0; tick(4);
        m_scl = 1'b1; tick(8);
        m_sda = 1'b1; tick(8);
    endtask

    task automatic clk_bit(input logic b, output logic seen);
        m_sda = b;    tick(4);
        m_scl = 1'b1; tick(4);
        seen  = bus_sda; tick(4);
        m_scl = 1'b0; tick(4);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        acked = !s;
    endtask

    task automatic read_byte(input bit mack, output logic [7:0] b);
        logic s;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, s);
            b = {b[6:0], s};
        end
        clk_bit(mack ? 1'b0 : 1'b1, s);
    endtask

    function automatic logic [7:0] selb(input logic [1:0] c, input logic a16, input logic rw);
        return {4'b1010, c, a16, rw};
    endfunction

    task automatic set_addr(input logic [16:0] a);
        logic ack;
        do_start();
        send_byte(selb(chip_en, a[16], 1'b0), ack); chk(ack, "R8 select", 32'(ack), 1);
        send_byte(a[15:8], ack); chk(ack, "R4 addr hi", 32'(ack), 1);
        send_byte(a[7:0], ack);  chk(ack, "R4 addr lo", 32'(ack), 1);
    endtask

    initial begin
        logic ack;
        logic [7:0] rb;
        int wr0;
        int rd0;

        tick(10);
        chk(sda_pull == 1'b0, "R1 pull in reset", 32'(sda_pull), 0);
        rst = 1'b0;
        tick(1);
        chk(!sda_pull && !mem_rd && !mem_wr, "R1 quiet after reset", {29'd0, sda_pull, mem_rd, mem_wr}, 0);
        tick(4);

        // R2 / R3: sweep of strap values against select chip bits
        for (int e = 0; e < 4; e++) begin
            for (int c = 0; c < 4; c++) begin
                chip_en = 2'(e);
                do_start();
                send_byte(selb(2'(c), 1'b0, 1'b0), ack);
                chk(ack == (e == c), (e == c) ? "R2 match ack" : "R3 mismatch no ack", 32'(ack), 32'(e == c));
                if (e != c) begin
                    send_byte(8'h00, ack);
                    chk(!ack, "R3 ignored after mismatch", 32'(ack), 0);
                end
                do_stop();
            end
        end
        chk(wr_n == 0 && rd_n == 0, "R3 no strobes", 32'(wr_n + rd_n), 0);

        // R2: wrong type code
        chip_en = 2'b01;
        do_start();
        send_byte(8'b1011_01_0_0, ack);
        chk(!ack, "R2 wrong type code", 32'(ack), 0);
        do_stop();

        // R4 / R5 / R9: write across the top of the address space
        set_addr(17'h1FFFE);
        send_byte(8'h11, ack); chk(ack, "R5 data ack 0", 32'(ack), 1);
        send_byte(8'h22, ack); chk(ack, "R5 data ack 1", 32'(ack), 1);
        send_byte(8'h33, ack); chk(ack, "R5 data ack 2", 32'(ack), 1);
        do_stop();
        chk(wr_n == 3, "R5 write count", 32'(wr_n), 3);
        chk(wa[0] == 17'h1FFFE && wd[0] == 8'h11, "R4 first write", {7'd0, wa[0], wd[0]}, {7'd0, 17'h1FFFE, 8'h11});
        chk(wa[1] == 17'h1FFFF && wd[1] == 8'h22, "R5 second write", {7'd0, wa[1], wd[1]}, {7'd0, 17'h1FFFF, 8'h22});
        chk(wa[2] == 17'h00000 && wd[2] == 8'h33, "R9 write wrap", {7'd0, wa[2], wd[2]}, {7'd0, 17'h0, 8'h33});

        // R8 / R6 / R7: random read, sequential
        set_addr(17'h01234);
        do_start();
        send_byte(selb(chip_en, 1'b0, 1'b1), ack); chk(ack, "R6 read select ack", 32'(ack), 1);
        read_byte(1'b1, rb); chk(rb == pat(17'h01234), "R8 random read", 32'(rb), 32'(pat(17'h01234)));
        read_byte(1'b1, rb); chk(rb == pat(17'h01235), "R7 sequential 1", 32'(rb), 32'(pat(17'h01235)));
        read_byte(1'b0, rb); chk(rb == pat(17'h01236), "R7 sequential 2", 32'(rb), 32'(pat(17'h01236)));
        tick(4);
        chk(sda_pull == 1'b0, "R7 released after noack", 32'(sda_pull), 0);
        do_stop();

        // R9: current-address read
        do_start();
        send_byte(selb(chip_en, 1'b0, 1'b1), ack); chk(ack, "R9 select ack", 32'(ack), 1);
        read_byte(1'b0, rb); chk(rb == pat(17'h01237), "R9 current address", 32'(rb), 32'(pat(17'h01237)));
        do_stop();

        // R9: read wraps
        set_addr(17'h1FFFF);
        do_start();
        send_byte(selb(chip_en, 1'b0, 1'b1), ack); chk(ack, "R9 wrap select", 32'(ack), 1);
        read_byte(1'b1, rb); chk(rb == pat(17'h1FFFF), "R9 read top", 32'(rb), 32'(pat(17'h1FFFF)));
        read_byte(1'b0, rb); chk(rb == pat(17'h00000), "R9 read wrap", 32'(rb), 32'(pat(17'h00000)));
        do_stop();

        // R10: start in the middle of an address byte
        wr0 = wr_n;
        do_start();
        send_byte(selb(chip_en, 1'b0, 1'b0), ack); chk(ack, "R10 select before abort", 32'(ack), 1);
        begin
            logic s;
            clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s); clk_bit(1'b0, s);
        end
        do_start();
        send_byte(selb(chip_en, 1'b0, 1'b1), ack); chk(ack, "R10 select after restart", 32'(ack), 1);
        read_byte(1'b0, rb); chk(rb == pat(17'h00001), "R10 pointer kept", 32'(rb), 32'(pat(17'h00001)));
        do_stop();
        chk(wr_n == wr0, "R10 no write", 32'(wr_n), 32'(wr0));

        // R11: stop then clocking without start
        wr0 = wr_n;
        rd0 = rd_n;
        do_start();
        send_byte(selb(chip_en, 1'b0, 1'b0), ack); chk(ack, "R11 select", 32'(ack), 1);
        send_byte(8'h00, ack);
        do_stop();
        m_scl = 1'b0; tick(4);
        send_byte(selb(chip_en, 1'b0, 1'b0), ack); chk(!ack, "R11 no ack without start", 32'(ack), 0);
        send_byte(8'h55, ack); chk(!ack, "R11 still idle", 32'(ack), 0);
        m_sda = 1'b0; tick(4);
        do_stop();
        chk(wr_n == wr0 && rd_n == rd0, "R11 no strobes", 32'(wr_n + rd_n), 32'(wr0 + rd0));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule